// File: doc/BRIEF.md
# Host memory address range decoder

This block routes each host memory access to one of three destinations: main DRAM, the external PCI bus or the X-bus. It takes a 32-bit physical address, a flag that says whether a processor or a PCI master started the access, and the processor's system-management-mode status. Configuration inputs give the top of main memory, an optional fixed hole in DRAM, an optional extended SMRAM window directly below the top of memory, and a routing select for the lower part of the high BIOS window.

Range matching is fully combinational. A set of window comparators feeds a priority selector, and the selected destination is registered. The result appears as a one-hot vector with a valid strobe one clock after the address strobe. Addresses are never remapped: DRAM that sits under the hole or under the SMRAM window simply cannot be reached through that address.

Top module: `memRouteTop`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `destValid` is 0 and `destOnehot` is 3'b000.
- R2: An access presented with `addrValid` high at a clock edge makes `destValid` high after that edge, with exactly one bit of `destOnehot` set (bit 0 DRAM, bit 1 PCI, bit 2 X-bus). After an edge with `addrValid` low, `destValid` is 0 and `destOnehot` is 3'b000.
- R3: Addresses below 0x0010_0000 route to PCI.
- R4: Addresses from 0x0010_0000 up to `tom`-1 route to DRAM when neither the hole nor the SMRAM window covers them.
- R5: With `holeEn`=1, DRAM-range addresses in [`holeBase`, `holeBase`+`holeSize`) route to PCI. The addresses just outside that range still route to DRAM, and nothing at or above `tom` becomes DRAM.
- R6: The SMRAM window is [`tom`-S, `tom`), where S is 128 KB, 256 KB, 512 KB or 1 MB for `smramCode` 0, 1, 2 or 3.
- R7: Inside the enabled SMRAM window, only a processor access (`initPci`=0) with `smmActive`=1 routes to DRAM. Every other access there routes to PCI. With `smramEn`=0 the window has no effect.
- R8: Addresses from `tom` up to 0xFFBF_FFFF route to PCI.
- R9: Addresses 0xFFF8_0000 to 0xFFFF_FFFF route to the X-bus whatever the configuration.
- R10: Addresses 0xFFC0_0000 to 0xFFF7_FFFF route to the X-bus when `biosToXbus`=1 and to PCI when it is 0.
- R11: The high BIOS rules win over the DRAM range, the SMRAM window and the hole. The SMRAM window wins over the hole.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous active-high reset |
| addrValid | input | 1 | Address strobe |
| addr | input | 32 | Physical address |
| initPci | input | 1 | 1 = PCI master initiated, 0 = processor |
| smmActive | input | 1 | Processor is in system management mode |
| tom | input | 32 | Top of main memory (exclusive) |
| holeEn | input | 1 | Fixed DRAM hole enable |
| holeBase | input | 32 | Hole base address |
| holeSize | input | 32 | Hole size in bytes |
| smramEn | input | 1 | Extended SMRAM window enable |
| smramCode | input | 2 | SMRAM window size code |
| biosToXbus | input | 1 | Lower high BIOS routing: 1 X-bus, 0 PCI |
| destOnehot | output | 3 | Registered destination {XBUS, PCI, DRAM} |
| destValid | output | 1 | Destination valid strobe |

## Verification
A comparator bound that is wrong shows up as a wrong destination one clock after an address sitting exactly on that bound. For this reason the sweep places addresses one below and exactly on every edge: 1 MB, the hole limits, each SMRAM size, the top of memory and both BIOS boundaries. A priority error can only be seen where windows overlap, so configurations are included where the SMRAM window sits inside the BIOS window and where the hole straddles the SMRAM window. A strobe register that stays stuck would show as a valid or zero destination held over from a previous access in the first idle cycle.

// File: rtl/memRoutePkg.sv
package memRoutePkg;
  localparam int DEST_W = 3;
  localparam logic [DEST_W-1:0] DEST_NONE = 3'b000;
  localparam logic [DEST_W-1:0] DEST_DRAM = 3'b001;
  localparam logic [DEST_W-1:0] DEST_PCI  = 3'b010;
  localparam logic [DEST_W-1:0] DEST_XBUS = 3'b100;

  localparam int WIN_DRAM    = 0;
  localparam int WIN_HOLE    = 1;
  localparam int WIN_SMRAM   = 2;
  localparam int WIN_BIOS    = 3;
  localparam int WIN_BIOSTOP = 4;
  localparam int NUM_WIN     = 5;

  typedef struct packed {
    logic              load;
    logic [DEST_W-1:0] dest;
  } routeStrobeT;
endpackage

// File: rtl/winCmp.sv
module winCmp #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W:0]   lo,
  input  logic [ADDR_W:0]   hiExcl,
  input  logic              enable,
  output logic              hit
);
  logic [ADDR_W:0] addrExt;
  assign addrExt = {1'b0, addr};
  assign hit = enable && (addrExt >= lo) && (addrExt < hiExcl);
endmodule

// File: rtl/rangeDp.sv
module rangeDp
  import memRoutePkg::*;
#(
  parameter int unsigned ADDR_W         = 32,
  parameter int unsigned CODE_W         = 2,
  parameter int unsigned SMRAM_MIN_LOG2 = 17,
  parameter logic [ADDR_W-1:0] LOW_BASE      = 32'h0010_0000,
  parameter logic [ADDR_W-1:0] BIOS_BASE     = 32'hFFC0_0000,
  parameter logic [ADDR_W-1:0] BIOS_TOP_BASE = 32'hFFF8_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] tom,
  input  logic              holeEn,
  input  logic [ADDR_W-1:0] holeBase,
  input  logic [ADDR_W-1:0] holeSize,
  input  logic              smramEn,
  input  logic [CODE_W-1:0] smramCode,
  input  routeStrobeT       strobe,
  output logic [NUM_WIN-1:0] winHit,
  output logic [DEST_W-1:0] destOut,
  output logic              destValid
);
  localparam logic [ADDR_W:0] SMRAM_MIN = (ADDR_W+1)'(1) << SMRAM_MIN_LOG2;
  localparam logic [ADDR_W:0] SPACE_END = {1'b1, {ADDR_W{1'b0}}};

  logic [ADDR_W:0] tomExt;
  logic [ADDR_W:0] smramSize;
  logic [ADDR_W:0] winLo [NUM_WIN];
  logic [ADDR_W:0] winHi [NUM_WIN];
  logic [NUM_WIN-1:0] winEn;
  logic [NUM_WIN-1:0] rawHit;

  assign tomExt    = {1'b0, tom};
  assign smramSize = SMRAM_MIN << smramCode;

  always_comb begin
    winLo[WIN_DRAM]    = {1'b0, LOW_BASE};
    winHi[WIN_DRAM]    = tomExt;
    winLo[WIN_HOLE]    = {1'b0, holeBase};
    winHi[WIN_HOLE]    = {1'b0, holeBase} + {1'b0, holeSize};
    winLo[WIN_SMRAM]   = (tomExt >= smramSize) ? (tomExt - smramSize) : '0;
    winHi[WIN_SMRAM]   = tomExt;
    winLo[WIN_BIOS]    = {1'b0, BIOS_BASE};
    winHi[WIN_BIOS]    = SPACE_END;
    winLo[WIN_BIOSTOP] = {1'b0, BIOS_TOP_BASE};
    winHi[WIN_BIOSTOP] = SPACE_END;
    winEn = '1;
    winEn[WIN_HOLE]  = holeEn;
    winEn[WIN_SMRAM] = smramEn;
  end

  for (genvar g = 0; g < NUM_WIN; g++) begin : gWin
    winCmp #(.ADDR_W(ADDR_W)) i_winCmp (
      .addr  (addr),
      .lo    (winLo[g]),
      .hiExcl(winHi[g]),
      .enable(winEn[g]),
      .hit   (rawHit[g])
    );
  end

  // hole and SMRAM only carve into the DRAM range
  always_comb begin
    winHit = rawHit;
    winHit[WIN_HOLE]  = rawHit[WIN_HOLE]  && rawHit[WIN_DRAM];
    winHit[WIN_SMRAM] = rawHit[WIN_SMRAM] && rawHit[WIN_DRAM];
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      destOut   <= DEST_NONE;
      destValid <= 1'b0;
    end else if (strobe.load) begin
      destOut   <= strobe.dest;
      destValid <= 1'b1;
    end else begin
      destOut   <= DEST_NONE;
      destValid <= 1'b0;
    end
  end
endmodule

// File: rtl/routeCtl.sv
module routeCtl
  import memRoutePkg::*;
(
  input  logic               addrValid,
  input  logic [NUM_WIN-1:0] winHit,
  input  logic               initPci,
  input  logic               smmActive,
  input  logic               biosToXbus,
  output routeStrobeT        strobe
);
  logic smmCpu;
  assign smmCpu = !initPci && smmActive;

  always_comb begin
    strobe.load = addrValid;
    if (winHit[WIN_BIOSTOP])      strobe.dest = DEST_XBUS;
    else if (winHit[WIN_BIOS])    strobe.dest = biosToXbus ? DEST_XBUS : DEST_PCI;
    else if (winHit[WIN_SMRAM])   strobe.dest = smmCpu ? DEST_DRAM : DEST_PCI;
    else if (winHit[WIN_HOLE])    strobe.dest = DEST_PCI;
    else if (winHit[WIN_DRAM])    strobe.dest = DEST_DRAM;
    else                          strobe.dest = DEST_PCI;
  end
endmodule

// File: rtl/memRouteTop.sv
module memRouteTop
  import memRoutePkg::*;
#(
  parameter int unsigned ADDR_W         = 32,
  parameter int unsigned CODE_W         = 2,
  parameter int unsigned SMRAM_MIN_LOG2 = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addrValid,
  input  logic [ADDR_W-1:0] addr,
  input  logic              initPci,
  input  logic              smmActive,
  input  logic [ADDR_W-1:0] tom,
  input  logic              holeEn,
  input  logic [ADDR_W-1:0] holeBase,
  input  logic [ADDR_W-1:0] holeSize,
  input  logic              smramEn,
  input  logic [CODE_W-1:0] smramCode,
  input  logic              biosToXbus,
  output logic [2:0]        destOnehot,
  output logic              destValid
);
  logic [NUM_WIN-1:0] winHit;
  routeStrobeT strobe;

  rangeDp #(
    .ADDR_W(ADDR_W), .CODE_W(CODE_W), .SMRAM_MIN_LOG2(SMRAM_MIN_LOG2)
  ) i_rangeDp (
    .clk(clk), .rst(rst), .addr(addr), .tom(tom),
    .holeEn(holeEn), .holeBase(holeBase), .holeSize(holeSize),
    .smramEn(smramEn), .smramCode(smramCode), .strobe(strobe),
    .winHit(winHit), .destOut(destOnehot), .destValid(destValid)
  );

  routeCtl i_routeCtl (
    .addrValid(addrValid), .winHit(winHit), .initPci(initPci),
    .smmActive(smmActive), .biosToXbus(biosToXbus), .strobe(strobe)
  );
endmodule

// File: rtl/memRouteChk.sv
module memRouteChk (
  input logic        clk,
  input logic        rst,
  input logic        addrValid,
  input logic [31:0] addr,
  input logic [31:0] tom,
  input logic        biosToXbus,
  input logic [2:0]  destOnehot,
  input logic        destValid
);
  assert_valid_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    destValid |-> $onehot(destOnehot));
  assert_idle_zero_R2: assert property (@(posedge clk) disable iff (rst)
    !destValid |-> destOnehot == 3'b000);
  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    addrValid |=> destValid);
  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
    !addrValid |=> !destValid);
  assert_low_pci_R3: assert property (@(posedge clk) disable iff (rst)
    (addrValid && addr < 32'h0010_0000) |=> destOnehot == 3'b010);
  assert_dram_bound_R4: assert property (@(posedge clk) disable iff (rst)
    (destValid && destOnehot == 3'b001) |->
      ($past(addr) >= 32'h0010_0000 && $past(addr) < $past(tom)));
  assert_bios_top_R9: assert property (@(posedge clk) disable iff (rst)
    (addrValid && addr >= 32'hFFF8_0000) |=> destOnehot == 3'b100);
  assert_bios_sel_R10: assert property (@(posedge clk) disable iff (rst)
    (addrValid && addr >= 32'hFFC0_0000 && addr < 32'hFFF8_0000) |=>
      destOnehot == ($past(biosToXbus) ? 3'b100 : 3'b010));
endmodule

bind memRouteTop memRouteChk i_memRouteChk (
  .clk(clk), .rst(rst), .addrValid(addrValid), .addr(addr), .tom(tom),
  .biosToXbus(biosToXbus), .destOnehot(destOnehot), .destValid(destValid)
);

// File: tb/test_memRouteTop.sv
module test_memRouteTop;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        addrValid = 1'b0;
  logic [31:0] addr = '0;
  logic        initPci = 1'b0;
  logic        smmActive = 1'b0;
  logic [31:0] tom = 32'h0800_0000;
  logic        holeEn = 1'b0;
  logic [31:0] holeBase = '0;
  logic [31:0] holeSize = '0;
  logic        smramEn = 1'b0;
  logic [1:0]  smramCode = '0;
  logic        biosToXbus = 1'b0;
  logic [2:0]  destOnehot;
  logic        destValid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  memRouteTop i_memRouteTop (
    .clk(clk), .rst(rst), .addrValid(addrValid), .addr(addr),
    .initPci(initPci), .smmActive(smmActive), .tom(tom),
    .holeEn(holeEn), .holeBase(holeBase), .holeSize(holeSize),
    .smramEn(smramEn), .smramCode(smramCode), .biosToXbus(biosToXbus),
    .destOnehot(destOnehot), .destValid(destValid)
  );

  task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s addr=%h tom=%h got={valid,dest}=%b expected=%b",
               tag, addr, tom, got, exp);
    end
  endtask

  // reference routing computed from the requirements
  task automatic model(input logic [31:0] a, output logic [2:0] d, output string tag);
    logic [63:0] a64, t64, sz, hb, he;
    a64 = 64'(a); t64 = 64'(tom);
    sz = 64'h2_0000 << smramCode;
    hb = 64'(holeBase); he = hb + 64'(holeSize);
    if (a64 >= 64'hFFF8_0000) begin
      d = 3'b100; tag = (a64 < t64) ? "R11" : "R9";
    end else if (a64 >= 64'hFFC0_0000) begin
      d = biosToXbus ? 3'b100 : 3'b010; tag = (a64 < t64) ? "R11" : "R10";
    end else if (a64 < 64'h10_0000) begin
      d = 3'b010; tag = "R3";
    end else if (a64 < t64) begin
      if (smramEn && a64 + sz >= t64) begin
        d = (!initPci && smmActive) ? 3'b001 : 3'b010;
        if (holeEn && a64 >= hb && a64 < he) tag = "R11";
        else if (a64 == t64 - sz) tag = "R6";
        else tag = "R7";
      end else if (holeEn && a64 >= hb && a64 < he) begin
        d = 3'b010; tag = "R5";
      end else begin
        d = 3'b001;
        tag = (smramEn && a64 + sz + 1 == t64) ? "R6" :
              (holeEn && (a64 + 1 == hb || a64 == he)) ? "R5" : "R4";
      end
    end else begin
      d = 3'b010; tag = "R8";
    end
  endtask

  task automatic access(input logic [31:0] a);
    logic [2:0] d;
    string tag;
    addr = a;
    addrValid = 1'b1;
    model(a, d, tag);
    @(negedge clk);
    check(tag, {destValid, destOnehot}, {1'b1, d});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] tomList [3];
    logic [31:0] pts [24];
    tomList[0] = 32'h0800_0000;
    tomList[1] = 32'h0020_0000;
    tomList[2] = 32'hFFE0_0000;
    repeat (3) @(negedge clk);
    check("R1", {destValid, destOnehot}, 4'b0000);
    rst = 1'b0;
    @(negedge clk);
    check("R1", {destValid, destOnehot}, 4'b0000);

    for (int ti = 0; ti < 3; ti++)
    for (int hs = 0; hs < 3; hs++)
    for (int se = 0; se < 2; se++)
    for (int sc = 0; sc < 4; sc++)
    for (int bx = 0; bx < 2; bx++)
    for (int ip = 0; ip < 2; ip++)
    for (int sm = 0; sm < 2; sm++) begin
      tom = tomList[ti];
      holeEn = (hs != 0);
      holeBase = (hs == 2) ? tom - 32'h8_0000 : 32'h0100_0000;
      holeSize = 32'h10_0000;
      smramEn = se[0];
      smramCode = sc[1:0];
      biosToXbus = bx[0];
      initPci = ip[0];
      smmActive = sm[0];
      pts[0]  = 32'h0;          pts[1]  = 32'h000F_FFFF;
      pts[2]  = 32'h0010_0000;  pts[3]  = holeBase - 1;
      pts[4]  = holeBase;       pts[5]  = holeBase + holeSize - 1;
      pts[6]  = holeBase + holeSize;
      pts[7]  = tom - 32'h2_0000 - 1;  pts[8]  = tom - 32'h2_0000;
      pts[9]  = tom - 32'h4_0000 - 1;  pts[10] = tom - 32'h4_0000;
      pts[11] = tom - 32'h8_0000 - 1;  pts[12] = tom - 32'h8_0000;
      pts[13] = tom - 32'h10_0000 - 1; pts[14] = tom - 32'h10_0000;
      pts[15] = tom - 1;        pts[16] = tom;
      pts[17] = tom + 32'h1000; pts[18] = 32'hFFBF_FFFF;
      pts[19] = 32'hFFC0_0000;  pts[20] = 32'hFFF7_FFFF;
      pts[21] = 32'hFFF8_0000;  pts[22] = 32'hFFFF_FFFF;
      pts[23] = 32'h8000_0000;
      for (int p = 0; p < 24; p++) access(pts[p]);
      addrValid = 1'b0;
      @(negedge clk);
      check("R2", {destValid, destOnehot}, 4'b0000);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule